// File: doc/BRIEF.md
# Round-Trip Delay Calibration Pipeline

This block sits in the receive path of a radio-equipment slave link, directly after the receive elastic buffer. It passes a word stream and its valid strobe through an adjustable delay line. It tunes the depth of that line so that the round-trip delay measured on the link stays as close as possible to a target that software programs.

Each time a new round-trip measurement arrives with the feature enabled, the block compares it with the target. It then moves the inserted delay one cycle up or down, or leaves it where it is. When the feature is off, the delay falls back to a fixed three cycles. The live depth is always readable, so software can include it in its receive-path delay accounting. A two-bit status reports whether the target is met exactly or cannot be reached at either end of the adjustment range.

The line holds up to 2^DELAY_AW words. With the default of 32 words, the inserted delay D runs from 0 to 31. A word sits in the line for D cycles and then crosses one output register, so the total latency through the block is D+1 cycles.

Top module: `rtd_cal_pipe`

## Requirements
- R1: While reset is high and on the first cycle after it, `delay_now` reads 3, `cal_status` reads 00 and `out_valid` is 0.
- R2: While `cal_enable` is 0, `delay_now` reads 3 on the cycle after, and measurements have no effect on the delay.
- R3: A word and its valid bit presented on the inputs during cycle c appear on `out_data`/`out_valid` during cycle c+D+1. D is the value `delay_now` shows during cycle c+D, and valid has exactly the same latency as data.
- R4: With `cal_enable` 1, a cycle with `meas_stb` 1 changes `delay_now` on the next cycle as follows:
  - if `meas_rtd` < `cal_target`, the delay rises by 1, but not above 31;
  - if `meas_rtd` > `cal_target`, the delay falls by 1, but not below 0;
  - if the two are equal, the delay is unchanged.
- R5: With `cal_enable` 1 and no `meas_stb`, `delay_now` does not change, so the delay moves by at most one cycle per clock.
- R6: `cal_status` is updated on the cycle after an enabled measurement:
  - 01 when the measurement equals the target;
  - 10 when the measurement is below the target and the delay is already 31;
  - 11 when the measurement is above the target and the delay is already 0;
  - unchanged for any other measurement.
  It reads 00 on the cycle after `cal_enable` is 0, and stays at 00 after re-enabling until one of the three conditions above occurs.
- R7: When `cal_enable` falls from 1 to 0, `delay_now` returns to 3 on the next cycle, from any depth, in a single step.
- R8: At delay 0 the latency is exactly one cycle: the output register takes the input word directly.
- R9: At delay 31 the latency is 32 cycles, the deepest the line allows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | DATA_W | Word from the elastic buffer |
| in_valid | input | 1 | Valid strobe for `in_data` |
| out_data | output | DATA_W | Delayed word |
| out_valid | output | 1 | Delayed valid strobe |
| cal_enable | input | 1 | 1 turns on automatic calibration |
| cal_target | input | RTD_W | Target round-trip delay |
| meas_rtd | input | RTD_W | Latest measured round-trip delay |
| meas_stb | input | 1 | One-cycle pulse marking a new `meas_rtd` |
| cal_status | output | 2 | 00 off/unsettled, 01 met, 10 stuck at max, 11 stuck at min |
| delay_now | output | DELAY_AW | Delay currently inserted, in cycles |

## Verification
The embedded assertions check the delay-control rules on every clock:
- the fixed depth of 3 and status 00 while disabled;
- no movement without a measurement;
- single-step moves on a measurement, including holding at 0 when pushed lower;
- the one-cycle bypass at delay 0.

Only the bench's scenarios can show the following:
- the end-to-end word latency of D+1 cycles as the delay moves through its range;
- the status codes reached after climbing to 31 or descending to 0;
- the snap back to 3 when calibration is switched off from a large depth.

// File: rtl/rtd_cal_pkg.sv
package rtd_cal_pkg;

  typedef enum logic [1:0] {
    CAL_OFF   = 2'b00,
    CAL_MET   = 2'b01,
    CAL_CEIL  = 2'b10,
    CAL_FLOOR = 2'b11
  } cal_status_e;

endpackage

// File: rtl/rtd_step_ctrl.sv
module rtd_step_ctrl
  import rtd_cal_pkg::*;
#(
  parameter int AW         = 5,
  parameter int RTD_W      = 20,
  parameter int IDLE_DELAY = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [RTD_W-1:0] target,
  input  logic [RTD_W-1:0] meas,
  input  logic             meas_stb,
  output logic [AW-1:0]    delay_q,
  output logic [1:0]       status_q
);

  localparam logic [AW-1:0] MAX_D  = '1;
  localparam logic [AW-1:0] IDLE_D = AW'(IDLE_DELAY);

  logic below, above, at_max, at_min;
  cal_status_e status_r;

  assign below  = meas < target;
  assign above  = meas > target;
  assign at_max = (delay_q == MAX_D);
  assign at_min = (delay_q == '0);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      delay_q  <= IDLE_D;
      status_r <= CAL_OFF;
    end else if (meas_stb) begin
      if (below && !at_max)
        delay_q <= delay_q + AW'(1);
      else if (above && !at_min)
        delay_q <= delay_q - AW'(1);

      if (!below && !above)
        status_r <= CAL_MET;
      else if (below && at_max)
        status_r <= CAL_CEIL;
      else if (above && at_min)
        status_r <= CAL_FLOOR;
    end
  end

  assign status_q = status_r;

  // R2: disabled line depth is fixed
  assert_idle_delay_R2: assert property (@(posedge clk) disable iff (rst)
    !enable |=> delay_q == IDLE_D);

  // R6: status reads off while disabled
  assert_idle_status_R6: assert property (@(posedge clk) disable iff (rst)
    !enable |=> status_q == 2'b00);

  // R5: no move without a measurement
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (enable && !meas_stb) |=> $stable(delay_q));

  // R4: single-step rise on a low measurement
  assert_step_up_R4: assert property (@(posedge clk) disable iff (rst)
    (enable && meas_stb && below && !at_max) |=> delay_q == $past(delay_q) + AW'(1));

  // R4: delay never wraps below zero
  assert_floor_R4: assert property (@(posedge clk) disable iff (rst)
    (enable && meas_stb && above && at_min) |=> delay_q == '0);

endmodule

// File: rtl/rtd_tap_line.sv
module rtd_tap_line #(
  parameter int DATA_W = 32,
  parameter int AW     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic [AW-1:0]     tap,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid
);

  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] store [DEPTH];
  logic [DEPTH-1:0]  vflag;
  logic [AW-1:0]     wr_ptr;
  logic [AW-1:0]     rd_idx;
  logic              bypass;

  assign rd_idx = wr_ptr - tap;
  assign bypass = (tap == '0);

  // data storage: no reset, single write and single read port
  always_ff @(posedge clk) begin
    store[wr_ptr] <= in_data;
    out_data      <= bypass ? in_data : store[rd_idx];
  end

  // valid flags and pointer: reset so stale words are never flagged
  always_ff @(posedge clk) begin
    if (rst) begin
      vflag     <= '0;
      wr_ptr    <= '0;
      out_valid <= 1'b0;
    end else begin
      vflag[wr_ptr] <= in_valid;
      wr_ptr        <= wr_ptr + AW'(1);
      out_valid     <= bypass ? in_valid : vflag[rd_idx];
    end
  end

  // R8: zero tap gives one-cycle latency
  assert_bypass_R8: assert property (@(posedge clk) disable iff (rst)
    (tap == '0) |=> (out_valid == $past(in_valid)) && (out_data == $past(in_data)));

endmodule

// File: rtl/rtd_cal_pipe.sv
module rtd_cal_pipe #(
  parameter int DATA_W     = 32,
  parameter int DELAY_AW   = 5,
  parameter int RTD_W      = 20,
  parameter int IDLE_DELAY = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   in_data,
  input  logic                in_valid,
  output logic [DATA_W-1:0]   out_data,
  output logic                out_valid,
  input  logic                cal_enable,
  input  logic [RTD_W-1:0]    cal_target,
  input  logic [RTD_W-1:0]    meas_rtd,
  input  logic                meas_stb,
  output logic [1:0]          cal_status,
  output logic [DELAY_AW-1:0] delay_now
);

  logic [DELAY_AW-1:0] tap;

  rtd_step_ctrl #(
    .AW(DELAY_AW), .RTD_W(RTD_W), .IDLE_DELAY(IDLE_DELAY)
  ) u_ctrl (
    .clk(clk), .rst(rst), .enable(cal_enable), .target(cal_target),
    .meas(meas_rtd), .meas_stb(meas_stb), .delay_q(tap), .status_q(cal_status)
  );

  rtd_tap_line #(
    .DATA_W(DATA_W), .AW(DELAY_AW)
  ) u_line (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .tap(tap), .out_data(out_data), .out_valid(out_valid)
  );

  assign delay_now = tap;

  // R1: reset leaves the idle depth in place
  assert_reset_depth_R1: assert property (@(posedge clk)
    rst |=> delay_now == DELAY_AW'(IDLE_DELAY));

endmodule

// File: tb/rtd_cal_pipe_test.sv
`timescale 1ns/1ps
module rtd_cal_pipe_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic [31:0] out_data;
  logic        out_valid;
  logic        cal_enable = 1'b0;
  logic [19:0] cal_target = 20'd1000;
  logic [19:0] meas_rtd = '0;
  logic        meas_stb = 1'b0;
  logic [1:0]  cal_status;
  logic [4:0]  delay_now;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rtd_cal_pipe uut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .out_data(out_data), .out_valid(out_valid), .cal_enable(cal_enable),
    .cal_target(cal_target), .meas_rtd(meas_rtd), .meas_stb(meas_stb),
    .cal_status(cal_status), .delay_now(delay_now)
  );

  // reference model state
  logic [31:0] hd [64];
  logic        hv [64];
  int n = 0;
  int m_delay = 3;
  int m_status = 0;
  logic m_en_prev = 1'b0;

  int exp_delay, exp_status;
  logic exp_valid;
  logic [31:0] exp_data;
  string tag_d, tag_s, tag_o;

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int next_delay(int d, logic en, logic stb, int meas, int tgt);
    if (!en) return 3;
    if (!stb) return d;
    if (meas < tgt && d < 31) return d + 1;
    if (meas > tgt && d > 0) return d - 1;
    return d;
  endfunction

  function automatic int next_status(int s, int d, logic en, logic stb, int meas, int tgt);
    if (!en) return 0;
    if (!stb) return s;
    if (meas == tgt) return 1;
    if (meas < tgt && d == 31) return 2;
    if (meas > tgt && d == 0) return 3;
    return s;
  endfunction

  // one cycle: inputs already driven; model on the edge; compare after it
  task automatic cyc();
    int idx;
    @(posedge clk);
    hd[n % 64] = in_data;
    hv[n % 64] = in_valid;
    idx = n - m_delay;
    exp_valid = (idx >= 0) ? hv[idx % 64] : 1'b0;
    exp_data  = (idx >= 0) ? hd[idx % 64] : '0;
    tag_o = (m_delay == 0) ? "R8" : (m_delay == 31) ? "R9" : "R3";
    if (!cal_enable) tag_d = m_en_prev ? "R7" : "R2";
    else tag_d = meas_stb ? "R4" : "R5";
    tag_s = "R6";
    exp_status = next_status(m_status, m_delay, cal_enable, meas_stb,
                             int'(meas_rtd), int'(cal_target));
    exp_delay  = next_delay(m_delay, cal_enable, meas_stb,
                            int'(meas_rtd), int'(cal_target));
    m_status = exp_status;
    m_delay  = exp_delay;
    m_en_prev = cal_enable;
    n++;
    @(negedge clk);
    chk(tag_d, int'(delay_now), exp_delay, "delay_now");
    chk(tag_s, int'(cal_status), exp_status, "cal_status");
    chk(tag_o, int'(out_valid), int'(exp_valid), "out_valid");
    if (exp_valid) chk(tag_o, int'(out_data), int'(exp_data), "out_data");
  endtask

  // mode 0 below target, 1 above, 2 equal, 3 near target with enable toggles
  task automatic run(input int cycles, input int mode);
    for (int i = 0; i < cycles; i++) begin
      in_data  = $urandom;
      in_valid = ($urandom % 4) != 0;
      meas_stb = ($urandom % 2) == 1;
      case (mode)
        0: meas_rtd = cal_target - 20'd7;
        1: meas_rtd = cal_target + 20'd9;
        2: meas_rtd = cal_target;
        default: begin
          meas_rtd = cal_target + 20'($urandom % 5) - 20'd2;
          if (($urandom % 48) == 0) cal_enable = ~cal_enable;
        end
      endcase
      cyc();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin hd[i] = '0; hv[i] = 1'b0; end
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", int'(delay_now), 3, "delay_now");
    chk("R1", int'(cal_status), 0, "cal_status");
    chk("R1", int'(out_valid), 0, "out_valid");
    rst = 1'b0;

    cal_enable = 1'b0;
    run(60, 0);            // R2: measurements ignored while disabled
    cal_enable = 1'b1;
    run(120, 0);           // R4 climb to 31, R6 ceiling, R9 depth
    run(40, 2);            // R6 met
    run(150, 1);           // R4 descend to 0, R6 floor, R8 bypass
    run(20, 0);
    cal_enable = 1'b0;
    run(10, 2);            // R7 snap back to 3
    cal_enable = 1'b1;
    run(90, 0);            // climb to ceiling again
    cal_enable = 1'b0;
    run(10, 3);            // R7 from depth 31
    cal_enable = 1'b1;
    run(2000, 3);          // mixed random
    cal_enable = 1'b0;
    run(10, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule